// File: doc/BRIEF.md
# Ring-Oscillator Random Bit Collection Controller

This block gathers random bits from a single entropy input into a 256-bit result buffer. Software reaches it over a plain 32-bit register bus. Software sets three things: how many clock cycles pass between two captured bits, how many bits to collect (64, 128, 192 or 256), and which of four oscillator sources to use. It then raises a start bit and polls that bit. Hardware drops the start bit once the requested number of bits is in the buffer, and software then reads the result words.

The control register is written through a mask held in the upper half of the written word. A write can therefore change single fields without first reading the register. While the generator is enabled, the block drives an oscillator enable output and a two-bit source select. The oscillators themselves sit outside the block.

A small state machine sequences the work. IDLE waits until start and enable are both 1. It then clears the buffer and bit count, loads the sample counter and moves to SAMPLE. SAMPLE counts down and captures one bit each time the counter expires. When the last requested bit has been captured, SAMPLE moves to FINISH. SAMPLE returns to IDLE if enable or start drops, or if software writes start again. FINISH lasts one cycle: it clears the start bit and returns to IDLE.

Top module: `trng_collect`

## Requirements
- R1: After reset, every register reads zero, all result words read zero, and both oscillator outputs are low.
- R2: The control register is at offset 0x400. Its fields are start in bit 0, enable in bit 1, source in bits 3:2 (00 is the fastest, 11 the slowest) and length in bits 5:4. A write changes low bit n only when bit n+16 of the written word is 1. Bits 31:6 read as zero.
- R3: The sample count register at offset 0x404 reads back the last value written to it.
- R4: While enable is 1, the oscillator enable output is high and the source select output equals the source field. While enable is 0, both outputs are zero.
- R5: While collecting, the block captures one entropy bit every N cycles, where N is the sample count and a sample count of 0 acts as 1. Captured bit k goes to bit k%32 of the result word at offset 0x410+4*(k/32).
- R6: Length code L requests 64*(L+1) bits. The start bit reads 0 exactly 64*(L+1)*N+2 cycles after the clock edge that took the start write.
- R7: Result words at or beyond index 2*(L+1) read as zero.
- R8: While enable is 0, a set start bit has no effect: no bit is captured, and start keeps reading 1.
- R9: Writing start=1 during a collection restarts it. The buffer and the bit count are cleared, and the full time of R6 runs again from that write.
- R10: Writing 0xFFFF0000 to the control register clears every control field and stops a running collection. The buffer then stays unchanged.
- R11: Reads of unmapped offsets, such as 0x000, 0x408 and 0x430, return zero.
- R12: If a start write lands on the same edge at which hardware would clear start, the write wins: start stays 1 and a new collection begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| osc_sel | output | 2 | Oscillator source select |
| osc_en | output | 1 | Oscillator enable |
| entropy_bit | input | 1 | Raw random bit from the selected oscillator |

## Verification
Two functions can fall in the same cycle: hardware clearing start in FINISH, and a software write that sets start again. The bench starts a collection and counts 64*N cycles from the start write. It then issues the second start write on exactly the edge at which FINISH clears start. The write counts as the winner only if start keeps reading 1, the new collection takes the full R6 time, and the buffer holds the second entropy pattern. A restart in the middle of SAMPLE is checked the same way: the buffer must hold only zeros after a run whose first bits were ones.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OFS_CTRL = 32'h400;
    localparam int unsigned OFS_SCNT = 32'h404;
    localparam int unsigned OFS_DOUT = 32'h410;

    // Control fields, bit 5 down to bit 0
    typedef struct packed {
        logic [1:0] len;
        logic [1:0] src;
        logic       enable;
        logic       start;
    } trng_ctrl_t;

    localparam int unsigned CTRL_W = $bits(trng_ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_FINISH = 2'd2
    } trng_state_e;

endpackage

// File: rtl/trng_regs.sv
module trng_regs
    import trng_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_done,
    output trng_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0]  scnt_o,
    output logic              kick_o
);

    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [CTRL_W-1:0] wmask;
    logic [CNT_W-1:0]  scnt_q;
    logic              ctrl_hit, scnt_hit;

    assign ctrl_hit = we && (addr == ADDR_W'(OFS_CTRL));
    assign scnt_hit = we && (addr == ADDR_W'(OFS_SCNT));
    assign wmask    = wdata[16 +: CTRL_W];
    assign kick_o   = ctrl_hit && wdata[16] && wdata[0];

    // The hardware clear is applied first, so a masked software write of start overrides it
    always_comb begin
        ctrl_d = ctrl_q;
        if (hw_done) begin
            ctrl_d[0] = 1'b0;
        end
        if (ctrl_hit) begin
            ctrl_d = (ctrl_d & ~wmask) | (wdata[CTRL_W-1:0] & wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            scnt_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (scnt_hit) begin
                scnt_q <= wdata[CNT_W-1:0];
            end
        end
    end

    assign ctrl_o = trng_ctrl_t'(ctrl_q);
    assign scnt_o = scnt_q;

    // R2: enable moves only through a write whose mask bit 17 is set
    a_r2_enable_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_hit && wdata[17]) |=> $stable(ctrl_q[1]));

    // R12: a start write always leaves start set, even against completion
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> ctrl_q[0]);

endmodule

// File: rtl/trng_fsm.sv
module trng_fsm
    import trng_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned MAX_BITS = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        enable,
    input  logic [1:0]                  len,
    input  logic [CNT_W-1:0]            scnt,
    input  logic                        kick,
    output logic                        capture_o,
    output logic                        clear_o,
    output logic                        done_o,
    output logic [$clog2(MAX_BITS)-1:0] bit_idx_o
);

    localparam int unsigned IDX_W = $clog2(MAX_BITS);
    localparam int unsigned CHUNK = MAX_BITS / 4;

    trng_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, reload;
    logic [IDX_W:0]   bits_q, tgt_q, tgt_d;
    logic             go, hit, last;

    assign go     = start && enable;
    assign reload = (scnt == '0) ? CNT_W'(1) : scnt;
    assign hit    = (cnt_q == CNT_W'(1));
    assign tgt_d  = (IDX_W+1)'((int'(len) + 1) * CHUNK);
    assign last   = (bits_q == tgt_q - 1'b1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (kick || !go)   state_d = ST_IDLE;
                else if (hit && last) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bits_q  <= '0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clear_o) begin
                cnt_q  <= reload;
                bits_q <= '0;
                tgt_q  <= tgt_d;
            end else if (capture_o) begin
                cnt_q  <= reload;
                bits_q <= bits_q + 1'b1;
            end else if (state_q == ST_SAMPLE) begin
                cnt_q  <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        capture_o = 1'b0;
        clear_o   = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   clear_o   = go;
            ST_SAMPLE: capture_o = go && !kick && hit;
            ST_FINISH: done_o    = 1'b1;
            default:   ;
        endcase
    end

    assign bit_idx_o = bits_q[IDX_W-1:0];

    // R8: with enable low the machine is back in IDLE one cycle later
    a_r8_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE));

    // R6: completion is always preceded by the final capture
    a_r6_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(capture_o));

    // R6: the bit count never passes the requested length
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q <= tgt_q);

endmodule

// File: rtl/trng_store.sv
module trng_store
    import trng_pkg::*;
#(
    parameter int unsigned MAX_BITS = 256
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic                                 capture,
    input  logic [$clog2(MAX_BITS)-1:0]          idx,
    input  logic                                 din,
    input  logic [$clog2(MAX_BITS/DATA_W)-1:0]   rd_word,
    input  logic [1:0]                           len,
    output logic [DATA_W-1:0]                    rd_data
);

    localparam int unsigned WORDS = MAX_BITS / DATA_W;
    localparam int unsigned WPC   = WORDS / 4;

    logic [MAX_BITS-1:0] buf_q;
    logic [DATA_W-1:0]   word_arr [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (clear) begin
            buf_q <= '0;
        end else if (capture) begin
            buf_q[idx] <= din;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign word_arr[w] = buf_q[w*DATA_W +: DATA_W];
    end

    always_comb begin
        if (int'(rd_word) < (int'(len) + 1) * WPC) rd_data = word_arr[rd_word];
        else                                        rd_data = '0;
    end

    // R9: a clear leaves an empty buffer
    a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (buf_q == '0));

    // R5: one capture touches at most one buffer bit
    a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ($countones(buf_q ^ $past(buf_q)) <= 1));

endmodule

// File: rtl/trng_collect.sv
module trng_collect
    import trng_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned MAX_BITS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        osc_sel,
    output logic              osc_en,
    input  logic              entropy_bit
);

    localparam int unsigned IDX_W  = $clog2(MAX_BITS);
    localparam int unsigned WORDS  = MAX_BITS / DATA_W;
    localparam int unsigned WSEL_W = $clog2(WORDS);

    trng_ctrl_t        ctrl;
    logic [CNT_W-1:0]  scnt;
    logic              kick, capture, clear, done;
    logic [IDX_W-1:0]  bit_idx;
    logic [WSEL_W-1:0] rd_word;
    logic [DATA_W-1:0] store_data;
    logic              in_dout;

    trng_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .hw_done (done),
        .ctrl_o  (ctrl),
        .scnt_o  (scnt),
        .kick_o  (kick)
    );

    trng_fsm #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ctrl.start),
        .enable    (ctrl.enable),
        .len       (ctrl.len),
        .scnt      (scnt),
        .kick      (kick),
        .capture_o (capture),
        .clear_o   (clear),
        .done_o    (done),
        .bit_idx_o (bit_idx)
    );

    assign rd_word = WSEL_W'((bus_addr - ADDR_W'(OFS_DOUT)) >> 2);
    assign in_dout = (bus_addr >= ADDR_W'(OFS_DOUT)) &&
                     (bus_addr <  ADDR_W'(OFS_DOUT + 4 * WORDS)) &&
                     (bus_addr[1:0] == 2'b00);

    trng_store #(.MAX_BITS(MAX_BITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .capture (capture),
        .idx     (bit_idx),
        .din     (entropy_bit),
        .rd_word (rd_word),
        .len     (ctrl.len),
        .rd_data (store_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))      bus_rdata = 32'(ctrl);
        else if (bus_addr == ADDR_W'(OFS_SCNT)) bus_rdata = 32'(scnt);
        else if (in_dout)                       bus_rdata = store_data;
    end

    assign osc_en  = ctrl.enable;
    assign osc_sel = ctrl.enable ? ctrl.src : 2'b00;

    // R10: a full-mask zero write leaves every control field cleared
    a_r10_full_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata == 32'hFFFF_0000)
        |=> (ctrl == '0));

endmodule

// File: tb/trng_collect_test.sv
`timescale 1ns/1ps
module trng_collect_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  osc_sel;
    logic        osc_en;
    logic        entropy_bit = 1'b0;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    trng_collect uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_sel(osc_sel),
        .osc_en(osc_en), .entropy_bit(entropy_bit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic pat_bit(input int mode, input int seed, input int k);
        int v;
        if (mode == 0) return 1'b0;
        v = k * 29 + seed * 7 + (k >> 2);
        return v[0] ^ v[3] ^ v[5];
    endfunction

    // Driver side of the scoreboard: expected result words
    task automatic predict(input int mode, input int seed, input int nbits, input int len, input string tag);
        for (int w = 0; w < 8; w++) begin
            logic [31:0] word = '0;
            if (w < (len + 1) * 2) begin
                for (int b = 0; b < 32; b++) begin
                    if (w * 32 + b < nbits) word[b] = pat_bit(mode, seed, w * 32 + b);
                end
            end
            exp_q.push_back(word);
            tag_q.push_back(tag);
        end
    endtask

    // Monitor side: read the result words and compare in order
    task automatic monitor_words();
        for (int w = 0; w < 8; w++) begin
            logic [31:0] d;
            bus_read(12'h410 + 12'(4 * w), d);
            check(tag_q.pop_front(), d, exp_q.pop_front());
        end
    endtask

    task automatic run_collect(input logic [31:0] cw, input int n, input int mode,
                               input int seed, input string tag);
        int eff = (n == 0) ? 1 : n;
        int len = int'(cw[5:4]);
        int nb  = 64 * (len + 1);
        int cyc = 0;
        bus_write(12'h400, cw);
        fork
            begin
                @(negedge clk);
                for (int k = 0; k < nb; k++) begin
                    entropy_bit = pat_bit(mode, seed, k);
                    repeat (eff) @(negedge clk);
                end
            end
            begin
                logic [31:0] d;
                bus_read(12'h400, d);
                while (d[0] && cyc < nb * eff + 50) begin
                    @(negedge clk);
                    cyc++;
                    bus_read(12'h400, d);
                end
            end
        join
        check({tag, " completion cycles"}, 32'(cyc), 32'(nb * eff + 2));
        predict(mode, seed, nb, len, tag);
        monitor_words();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, keep;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(12'h400, d); check("R1 ctrl", d, 0);
        bus_read(12'h404, d); check("R1 scnt", d, 0);
        bus_read(12'h410, d); check("R1 word0", d, 0);
        check("R1 osc", {30'd0, osc_sel}, 0);
        check("R1 osc_en", 32'(osc_en), 0);

        // R3 sample count
        bus_write(12'h404, 32'h0000_ABCD);
        bus_read(12'h404, d); check("R3 scnt", d, 32'h0000_ABCD);

        // R11 unmapped
        bus_read(12'h000, d); check("R11 0x000", d, 0);
        bus_read(12'h408, d); check("R11 0x408", d, 0);
        bus_read(12'h430, d); check("R11 0x430", d, 0);

        // R2 masked writes
        bus_write(12'h400, 32'h003E_0036);
        bus_read(12'h400, d); check("R2 masked set", d, 32'h36);
        bus_write(12'h400, 32'h0004_0000);
        bus_read(12'h400, d); check("R2 single bit clear", d, 32'h32);
        bus_write(12'h400, 32'h000C_0008);
        bus_read(12'h400, d); check("R2 source field", d, 32'h3A);
        // R4 oscillator outputs
        check("R4 sel on", {30'd0, osc_sel}, 2);
        check("R4 en on", 32'(osc_en), 1);
        bus_write(12'h400, 32'h0002_0000);
        check("R4 sel off", {30'd0, osc_sel}, 0);
        check("R4 en off", 32'(osc_en), 0);

        // R8 start while disabled
        bus_write(12'h400, 32'h0001_0001);
        entropy_bit = 1'b1;
        repeat (40) @(negedge clk);
        bus_read(12'h400, d); check("R8 start held", d, 32'h39);
        bus_read(12'h410, d); check("R8 word0 untouched", d, 0);
        bus_read(12'h42C, d); check("R8 word7 untouched", d, 0);

        // R10 full clear
        bus_write(12'h400, 32'hFFFF_0000);
        bus_read(12'h400, d); check("R10 ctrl cleared", d, 0);

        // R5 R6 R7 collections
        bus_write(12'h404, 32'd2);
        run_collect(32'h003F_0003, 2, 1, 1, "R5 R7 len64 N2");
        bus_write(12'h404, 32'd0);
        run_collect(32'h003F_0033, 0, 1, 2, "R6 len256 N0");
        bus_write(12'h404, 32'd3);
        run_collect(32'h003F_0013, 3, 1, 3, "R7 len128 N3");

        // R9 restart mid-run
        bus_write(12'h404, 32'd2);
        entropy_bit = 1'b1;
        bus_write(12'h400, 32'h003F_0003);
        repeat (30) @(negedge clk);
        run_collect(32'h003F_0003, 2, 0, 0, "R9 restart");

        // R12 start write on the completion edge
        entropy_bit = 1'b1;
        bus_write(12'h400, 32'h003F_0003);
        repeat (128) @(negedge clk);
        run_collect(32'h003F_0003, 2, 1, 5, "R12 same edge");

        // R10 stop during collection
        entropy_bit = 1'b1;
        bus_write(12'h400, 32'h003F_0003);
        repeat (20) @(negedge clk);
        bus_write(12'h400, 32'hFFFF_0000);
        bus_read(12'h400, d); check("R10 stop ctrl", d, 0);
        check("R10 stop osc_en", 32'(osc_en), 0);
        bus_write(12'h400, 32'h0030_0000);
        bus_read(12'h410, keep);
        repeat (40) @(negedge clk);
        bus_read(12'h410, d); check("R10 buffer frozen", d, keep);
        check("R10 partial bits", 32'(d != 0), 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule